// File: doc/BRIEF.md
# Indexed Video Gate Array Register Block

This block is the register front end of a small video gate array that shares system memory with the processor. Software programs it through one write port: the first write after the port is synchronised sets an index, and the next write stores its value in the register that index selects. An internal phase flag alternates on every write. Reading the status port clears that flag, so software always knows the next write is an index. Behind the port are a mode register, a palette mask, a border colour, a second control register and sixteen 4-bit palette entries. An index write with bit 4 set also blanks the display.

A separate page register holds three fields. One picks the 16 KB memory page the display fetches from, one picks the page the processor window maps to, and the last is a 2-bit address mode. The block forms the display memory address from the CRT controller character address, the CRT controller row counter and the display page. In the interleaved modes, row-counter bits take the place of one address bit and of the lowest page bit, which spreads scan lines across two or four banks. The block also builds the processor-side memory address by placing the processor page above the window offset.

Top module: `jr_video_gate`

## Requirements
- R1: A port write while the phase flag is clear loads the index register and sets the flag. A port write while the flag is set stores the value into the register the index selects and clears the flag. The flag is visible on `index_phase`.
- R2: A status read clears the phase flag. A port write in the same cycle still uses the flag's value from before that cycle.
- R3: Each index write copies index bit 4 into an index-blank source. `video_blank` is high whenever that source is set or mode bit 3 is clear.
- R4: Mode register bit 3 is the video enable. Setting it removes the mode blank source, and clearing it blanks the display.
- R5: Index 0x00 writes the mode register, 0x01 the palette mask, 0x02 the border colour and 0x03 the second control register. Each of these takes all 8 bits.
- R6: Indices 0x10 to 0x1F write the low 4 bits of the value into palette entries 0 to 15, and the upper 4 bits are dropped. `pal_color` shows the entry that `pal_sel` selects.
- R7: A data write to any other index changes no register and no palette entry.
- R8: A page-register write loads bits 2:0 as the display page, bits 5:3 as the processor page and bits 7:6 as the address mode. The reset value is 0x3F.
- R9: `disp_addr` is the effective display page times 16384 plus the effective 14-bit character address. In mode 0 the character address passes through unchanged.
- R10: In modes 1 and 3, bit 12 of the effective character address is row-counter bit 0.
- R11: In modes 2 and 3, the effective page bit 0 is row-counter bit 1, and the programmed display page bit 0 is ignored.
- R12: `cpu_addr` is the processor page times 16384 plus `cpu_off` bits 13:0. Offset bit 14 has no effect, so each page appears twice across the 32 KB window.
- R13: After reset the phase flag, the index-blank source, all four control registers and all palette entries are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_wr | input | 1 | Write strobe for the shared index/data port |
| port_wdata | input | 8 | Write data for the shared port |
| status_rd | input | 1 | Status read strobe; clears the phase flag |
| page_wr | input | 1 | Write strobe for the page register |
| page_wdata | input | 8 | Page register value |
| crtc_addr | input | 14 | CRT controller character address |
| crtc_row | input | 5 | CRT controller row counter |
| cpu_off | input | 15 | Processor offset inside the 32 KB window |
| pal_sel | input | 4 | Palette entry selected for `pal_color` |
| index_phase | output | 1 | Phase flag (1 means the next write is data) |
| video_blank | output | 1 | Display blank |
| mode_ctl | output | 8 | Mode register |
| pal_mask | output | 8 | Palette mask register |
| border_color | output | 8 | Border colour register |
| ctl2 | output | 8 | Second control register |
| pal_color | output | 4 | Selected palette entry |
| disp_page | output | 3 | Programmed display page |
| cpu_page | output | 3 | Programmed processor page |
| addr_mode | output | 2 | Programmed address mode |
| disp_addr | output | 17 | Display memory address |
| cpu_addr | output | 17 | Processor memory address |

## Verification
The embedded properties check the phase-flag rules on every cycle: toggling on writes, clearing on status reads, index capture and the copy of the blank bit. They also check that registers hold while no data write occurs, that page writes load, and that the address bit-substitution rules are consistent between the inputs and `disp_addr` and `cpu_addr`. Other behaviours depend on a write sequence, and only the bench scenarios show them. These are routing each index to the right register, dropping the upper palette nibble, ignoring unlisted indices, a status read racing a data write, and the full address arithmetic across every mode, page and row combination.

// File: rtl/vgate_pkg.sv
package vgate_pkg;
   localparam int unsigned REG_MODE   = 0;
   localparam int unsigned REG_PMASK  = 1;
   localparam int unsigned REG_BORDER = 2;
   localparam int unsigned REG_CTL2   = 3;
   localparam int unsigned PAL_BASE   = 16;
   localparam int unsigned BLANK_BIT  = 4;
   localparam int unsigned VIDEO_EN_BIT = 3;
   localparam int unsigned SPLIT_BIT  = 12;

   typedef enum logic [1:0] {
      AM_LINEAR    = 2'd0,
      AM_ROW_A12   = 2'd1,
      AM_ROW_PG0   = 2'd2,
      AM_FOUR_BANK = 2'd3
   } addr_mode_t;
endpackage

// File: rtl/vgate_port_ctl.sv
module vgate_port_ctl #(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned BLANK_BIT = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              stat_rd,
   output logic              phase,
   output logic [DATA_W-1:0] idx_q,
   output logic              idx_blank,
   output logic              data_wr
);
   initial begin
      assert (BLANK_BIT < DATA_W) else $error("blank bit outside data width");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase     <= 1'b0;
         idx_q     <= '0;
         idx_blank <= 1'b0;
      end else begin
         if (stat_rd)
            phase <= 1'b0;
         else if (wr_en)
            phase <= ~phase;
         if (wr_en && !phase) begin
            idx_q     <= wr_data;
            idx_blank <= wr_data[BLANK_BIT];
         end
      end
   end

   assign data_wr = wr_en & phase;

   a_r1_phase_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !stat_rd) |=> (phase != $past(phase)));
   a_r1_index_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !phase) |=> (idx_q == $past(wr_data)));
   a_r2_status_clears: assert property (@(posedge clk) disable iff (!rst_n)
      stat_rd |=> !phase);
   a_r3_blank_copy: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !phase) |=> (idx_blank == $past(wr_data[BLANK_BIT])));
   a_r1_index_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && !phase) |=> $stable(idx_q));
endmodule

// File: rtl/vgate_regfile.sv
module vgate_regfile #(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned PAL_N    = 16,
   parameter int unsigned PAL_W    = 4,
   parameter int unsigned IDX_BASE = 16,
   localparam int unsigned PSEL_W  = (PAL_N > 1) ? $clog2(PAL_N) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              data_wr,
   input  logic [DATA_W-1:0] idx,
   input  logic [DATA_W-1:0] wdata,
   input  logic [PSEL_W-1:0] pal_sel,
   output logic [DATA_W-1:0] mode_q,
   output logic [DATA_W-1:0] pmask_q,
   output logic [DATA_W-1:0] border_q,
   output logic [DATA_W-1:0] ctl2_q,
   output logic [PAL_W-1:0]  pal_out
);
   import vgate_pkg::*;

   initial begin
      assert (IDX_BASE + PAL_N <= (1 << DATA_W)) else $error("palette index range too wide");
      assert (PAL_W <= DATA_W) else $error("palette entry wider than data");
      assert ((1 << PSEL_W) == PAL_N) else $error("palette count must be a power of two");
      assert (IDX_BASE > REG_CTL2) else $error("palette overlaps control registers");
   end

   logic [PAL_W-1:0] pal_vec [PAL_N];

   for (genvar i = 0; i < PAL_N; i++) begin : g_pal
      logic [PAL_W-1:0] ent_q;
      logic             hit;
      assign hit = data_wr && (idx == DATA_W'(IDX_BASE + i));
      always_ff @(posedge clk) begin
         if (!rst_n)
            ent_q <= '0;
         else if (hit)
            ent_q <= wdata[PAL_W-1:0];
      end
      assign pal_vec[i] = ent_q;
   end

   assign pal_out = pal_vec[pal_sel];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q   <= '0;
         pmask_q  <= '0;
         border_q <= '0;
         ctl2_q   <= '0;
      end else if (data_wr) begin
         if (idx == DATA_W'(REG_MODE))   mode_q   <= wdata;
         if (idx == DATA_W'(REG_PMASK))  pmask_q  <= wdata;
         if (idx == DATA_W'(REG_BORDER)) border_q <= wdata;
         if (idx == DATA_W'(REG_CTL2))   ctl2_q   <= wdata;
      end
   end

   a_r7_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !data_wr |=> ($stable(mode_q) && $stable(pmask_q) && $stable(border_q) && $stable(ctl2_q)));
   a_r5_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && idx == DATA_W'(REG_MODE)) |=> (mode_q == $past(wdata)));
   a_r6_pal_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !data_wr |=> $stable(pal_out) || !$stable(pal_sel));
endmodule

// File: rtl/vgate_page_map.sv
module vgate_page_map #(
   parameter int unsigned PAGE_W    = 3,
   parameter int unsigned CA_W      = 14,
   parameter int unsigned ROW_W     = 5,
   parameter int unsigned SPLIT_BIT = 12,
   localparam int unsigned PG_REG_W = 2 * PAGE_W + 2,
   localparam int unsigned MA_W     = PAGE_W + CA_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                page_wr,
   input  logic [PG_REG_W-1:0] page_data,
   input  logic [CA_W-1:0]     crtc_addr,
   input  logic [ROW_W-1:0]    crtc_row,
   input  logic [CA_W:0]       cpu_off,
   output logic [PAGE_W-1:0]   disp_page,
   output logic [PAGE_W-1:0]   cpu_page,
   output logic [1:0]          amode,
   output logic [MA_W-1:0]     disp_addr,
   output logic [MA_W-1:0]     cpu_addr
);
   initial begin
      assert (ROW_W >= 2) else $error("row counter needs two bits");
      assert (SPLIT_BIT < CA_W) else $error("split bit outside character address");
      assert (PAGE_W >= 2) else $error("page field too narrow");
   end

   localparam logic [PG_REG_W-1:0] PAGE_RST = {2'b00, {(2*PAGE_W){1'b1}}};

   logic [PG_REG_W-1:0] page_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         page_q <= PAGE_RST;
      else if (page_wr)
         page_q <= page_data;
   end

   assign disp_page = page_q[PAGE_W-1:0];
   assign cpu_page  = page_q[2*PAGE_W-1:PAGE_W];
   assign amode     = page_q[PG_REG_W-1:PG_REG_W-2];

   logic [CA_W-1:0]   lo_addr;
   logic [PAGE_W-1:0] pg_eff;

   for (genvar b = 0; b < CA_W; b++) begin : g_lo
      if (b == SPLIT_BIT) begin : g_sub
         assign lo_addr[b] = amode[0] ? crtc_row[0] : crtc_addr[b];
      end else begin : g_pass
         assign lo_addr[b] = crtc_addr[b];
      end
   end

   assign pg_eff    = {disp_page[PAGE_W-1:1], amode[1] ? crtc_row[1] : disp_page[0]};
   assign disp_addr = {pg_eff, lo_addr};
   assign cpu_addr  = {cpu_page, cpu_off[CA_W-1:0]};

   logic [ROW_W-1:0] unused_bits;
   assign unused_bits = {crtc_row[ROW_W-1:2], 2'b00} ^ {{(ROW_W-1){1'b0}}, cpu_off[CA_W]};

   a_r8_page_load: assert property (@(posedge clk) disable iff (!rst_n)
      page_wr |=> ({amode, cpu_page, disp_page} == $past(page_data)));
   a_r9_linear_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (amode == 2'd0) |-> (disp_addr == {disp_page, crtc_addr}));
   a_r10_row_a12: assert property (@(posedge clk) disable iff (!rst_n)
      amode[0] |-> (disp_addr[SPLIT_BIT] == crtc_row[0]));
   a_r11_row_pg0: assert property (@(posedge clk) disable iff (!rst_n)
      amode[1] |-> (disp_addr[CA_W] == crtc_row[1]));
   a_r12_cpu_alias: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_addr[CA_W-1:0] == cpu_off[CA_W-1:0]) && (cpu_addr[MA_W-1:CA_W] == page_q[2*PAGE_W-1:PAGE_W]));
endmodule

// File: rtl/jr_video_gate.sv
module jr_video_gate #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned PAGE_W = 3,
   parameter int unsigned CA_W   = 14,
   parameter int unsigned ROW_W  = 5,
   parameter int unsigned PAL_N  = 16,
   parameter int unsigned PAL_W  = 4,
   localparam int unsigned MA_W     = PAGE_W + CA_W,
   localparam int unsigned PG_REG_W = 2 * PAGE_W + 2,
   localparam int unsigned PSEL_W   = (PAL_N > 1) ? $clog2(PAL_N) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                port_wr,
   input  logic [DATA_W-1:0]   port_wdata,
   input  logic                status_rd,
   input  logic                page_wr,
   input  logic [PG_REG_W-1:0] page_wdata,
   input  logic [CA_W-1:0]     crtc_addr,
   input  logic [ROW_W-1:0]    crtc_row,
   input  logic [CA_W:0]       cpu_off,
   input  logic [PSEL_W-1:0]   pal_sel,
   output logic                index_phase,
   output logic                video_blank,
   output logic [DATA_W-1:0]   mode_ctl,
   output logic [DATA_W-1:0]   pal_mask,
   output logic [DATA_W-1:0]   border_color,
   output logic [DATA_W-1:0]   ctl2,
   output logic [PAL_W-1:0]    pal_color,
   output logic [PAGE_W-1:0]   disp_page,
   output logic [PAGE_W-1:0]   cpu_page,
   output logic [1:0]          addr_mode,
   output logic [MA_W-1:0]     disp_addr,
   output logic [MA_W-1:0]     cpu_addr
);
   import vgate_pkg::*;

   initial begin
      assert (VIDEO_EN_BIT < DATA_W) else $error("video enable bit outside data width");
   end

   logic [DATA_W-1:0] idx_q;
   logic              idx_blank;
   logic              data_wr;

   vgate_port_ctl #(.DATA_W(DATA_W), .BLANK_BIT(BLANK_BIT)) u_port (
      .clk(clk), .rst_n(rst_n), .wr_en(port_wr), .wr_data(port_wdata),
      .stat_rd(status_rd), .phase(index_phase), .idx_q(idx_q),
      .idx_blank(idx_blank), .data_wr(data_wr)
   );

   vgate_regfile #(.DATA_W(DATA_W), .PAL_N(PAL_N), .PAL_W(PAL_W), .IDX_BASE(PAL_BASE)) u_regs (
      .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .idx(idx_q), .wdata(port_wdata),
      .pal_sel(pal_sel), .mode_q(mode_ctl), .pmask_q(pal_mask),
      .border_q(border_color), .ctl2_q(ctl2), .pal_out(pal_color)
   );

   vgate_page_map #(.PAGE_W(PAGE_W), .CA_W(CA_W), .ROW_W(ROW_W), .SPLIT_BIT(SPLIT_BIT)) u_page (
      .clk(clk), .rst_n(rst_n), .page_wr(page_wr), .page_data(page_wdata),
      .crtc_addr(crtc_addr), .crtc_row(crtc_row), .cpu_off(cpu_off),
      .disp_page(disp_page), .cpu_page(cpu_page), .amode(addr_mode),
      .disp_addr(disp_addr), .cpu_addr(cpu_addr)
   );

   assign video_blank = idx_blank | ~mode_ctl[VIDEO_EN_BIT];

   a_r4_enable_unblanks: assert property (@(posedge clk) disable iff (!rst_n)
      (!video_blank) |-> (mode_ctl[VIDEO_EN_BIT] && !u_port.idx_blank));
   a_r3_index_blanks: assert property (@(posedge clk) disable iff (!rst_n)
      (port_wr && !index_phase && port_wdata[BLANK_BIT]) |=> video_blank);
endmodule

// File: tb/jr_video_gate_tb.sv
module jr_video_gate_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        port_wr = 1'b0;
   logic [7:0]  port_wdata = '0;
   logic        status_rd = 1'b0;
   logic        page_wr = 1'b0;
   logic [7:0]  page_wdata = '0;
   logic [13:0] crtc_addr = '0;
   logic [4:0]  crtc_row = '0;
   logic [14:0] cpu_off = '0;
   logic [3:0]  pal_sel = '0;
   logic        index_phase, video_blank;
   logic [7:0]  mode_ctl, pal_mask, border_color, ctl2;
   logic [3:0]  pal_color;
   logic [2:0]  disp_page, cpu_page;
   logic [1:0]  addr_mode;
   logic [16:0] disp_addr, cpu_addr;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   jr_video_gate u_dut (
      .clk(clk), .rst_n(rst_n), .port_wr(port_wr), .port_wdata(port_wdata),
      .status_rd(status_rd), .page_wr(page_wr), .page_wdata(page_wdata),
      .crtc_addr(crtc_addr), .crtc_row(crtc_row), .cpu_off(cpu_off), .pal_sel(pal_sel),
      .index_phase(index_phase), .video_blank(video_blank), .mode_ctl(mode_ctl),
      .pal_mask(pal_mask), .border_color(border_color), .ctl2(ctl2), .pal_color(pal_color),
      .disp_page(disp_page), .cpu_page(cpu_page), .addr_mode(addr_mode),
      .disp_addr(disp_addr), .cpu_addr(cpu_addr)
   );

   always #2 clk = ~clk;

   task automatic chk(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic pwr(input logic [7:0] v);
      @(negedge clk); port_wr = 1'b1; port_wdata = v;
      @(negedge clk); port_wr = 1'b0;
   endtask

   task automatic set_reg(input logic [7:0] idx, input logic [7:0] v);
      pwr(idx); pwr(v);
   endtask

   task automatic set_page(input logic [7:0] v);
      @(negedge clk); page_wr = 1'b1; page_wdata = v;
      @(negedge clk); page_wr = 1'b0;
   endtask

   function automatic int exp_disp(int pg, int m, int row, int ca);
      int a, p;
      a = ca;
      p = pg;
      if (m % 2 == 1) a = (a & 'h2FFF) | ((row % 2) << 12);
      if (m >= 2) p = (p & 6) | ((row / 2) % 2);
      return p * 16384 + a;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++; tests++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R13 reset state, R8 page reset 0x3F
      chk("R13 phase", index_phase, 0);
      chk("R13 mode", mode_ctl, 0);
      chk("R13 mask", pal_mask, 0);
      chk("R13 border", border_color, 0);
      chk("R13 ctl2", ctl2, 0);
      for (int i = 0; i < 16; i++) begin
         pal_sel = 4'(i); #1;
         chk("R13 palette", pal_color, 0);
      end
      chk("R8 reset disp page", disp_page, 7);
      chk("R8 reset cpu page", cpu_page, 7);
      chk("R8 reset mode", addr_mode, 0);
      chk("R4 blank at reset", video_blank, 1);

      // R1 phase alternation
      pwr(8'h02);
      chk("R1 phase after index", index_phase, 1);
      pwr(8'hA5);
      chk("R1 phase after data", index_phase, 0);
      chk("R1 data to border", border_color, 'hA5);

      // R5 control registers
      set_reg(8'h00, 8'h08); chk("R5 mode", mode_ctl, 'h08);
      chk("R4 enable unblanks", video_blank, 0);
      set_reg(8'h01, 8'h3C); chk("R5 mask", pal_mask, 'h3C);
      set_reg(8'h02, 8'hC3); chk("R5 border", border_color, 'hC3);
      set_reg(8'h03, 8'h5A); chk("R5 ctl2", ctl2, 'h5A);

      // R3 index blank source
      pwr(8'h13);
      chk("R3 bit4 index blanks", video_blank, 1);
      pwr(8'hF9);
      chk("R3 blank held over data", video_blank, 1);
      pwr(8'h02);
      chk("R3 bit4 clear unblanks", video_blank, 0);
      pwr(8'hC3);
      // R4 mode bit 3 clear blanks
      set_reg(8'h00, 8'hF7); chk("R4 enable clear blanks", video_blank, 1);
      set_reg(8'h00, 8'h08); chk("R4 enable set", video_blank, 0);

      // R6 palette sweep, upper nibble dropped
      for (int i = 0; i < 16; i++)
         set_reg(8'(16 + i), {4'(15 - i), 4'((i * 5 + 3) % 16)});
      for (int i = 0; i < 16; i++) begin
         pal_sel = 4'(i); #1;
         chk("R6 palette entry", pal_color, (i * 5 + 3) % 16);
      end

      // R7 ignored indices
      for (int k = 4; k < 16; k++) set_reg(8'(k), 8'hFF);
      set_reg(8'h20, 8'hFF);
      set_reg(8'h30, 8'hFF);
      set_reg(8'hFF, 8'hFF);
      chk("R7 mode kept", mode_ctl, 'h08);
      chk("R7 mask kept", pal_mask, 'h3C);
      chk("R7 border kept", border_color, 'hC3);
      chk("R7 ctl2 kept", ctl2, 'h5A);
      for (int i = 0; i < 16; i++) begin
         pal_sel = 4'(i); #1;
         chk("R7 palette kept", pal_color, (i * 5 + 3) % 16);
      end

      // R2 status read clears phase
      pwr(8'h02);
      @(negedge clk); status_rd = 1'b1;
      @(negedge clk); status_rd = 1'b0;
      chk("R2 status clears phase", index_phase, 0);
      pwr(8'h03); pwr(8'h11);
      chk("R2 next write was index", ctl2, 'h11);
      chk("R2 border untouched", border_color, 'hC3);
      // R2 status read racing a data write
      pwr(8'h02);
      @(negedge clk); status_rd = 1'b1; port_wr = 1'b1; port_wdata = 8'h66;
      @(negedge clk); status_rd = 1'b0; port_wr = 1'b0;
      chk("R2 race data stored", border_color, 'h66);
      chk("R2 race phase clear", index_phase, 0);

      // R8..R11 address sweep
      for (int m = 0; m < 4; m++) begin
         for (int pg = 0; pg < 8; pg++) begin
            set_page(8'((m << 6) | ((7 - pg) << 3) | pg));
            chk("R8 disp page", disp_page, pg);
            chk("R8 cpu page", cpu_page, 7 - pg);
            chk("R8 mode", addr_mode, m);
            for (int row = 0; row < 4; row++) begin
               for (int c = 0; c < 3; c++) begin
                  crtc_row = 5'(row + 4 * c);
                  crtc_addr = (c == 0) ? 14'h0000 : (c == 1) ? 14'h3FFF : 14'(pg * 977 + row * 131);
                  #1;
                  if (m == 0)
                     chk("R9 linear address", disp_addr, exp_disp(pg, m, row, int'(crtc_addr)));
                  else if (m == 1)
                     chk("R10 row bit0 into a12", disp_addr, exp_disp(pg, m, row, int'(crtc_addr)));
                  else
                     chk("R11 row bit1 into page", disp_addr, exp_disp(pg, m, row, int'(crtc_addr)));
               end
            end
         end
      end

      // R12 processor window aliasing
      for (int pg = 0; pg < 8; pg++) begin
         set_page(8'(pg << 3));
         for (int o = 0; o < 4; o++) begin
            cpu_off = 15'((o * 8191 + 5) % 16384);
            #1;
            chk("R12 cpu low half", cpu_addr, pg * 16384 + (o * 8191 + 5) % 16384);
            cpu_off = cpu_off | 15'h4000;
            #1;
            chk("R12 cpu alias half", cpu_addr, pg * 16384 + (o * 8191 + 5) % 16384);
         end
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule